// File: doc/BRIEF.md
# Terminal Cursor and Character Address Counters

This block holds the character RAM address of a video terminal as two modulo counters: a column counter that runs modulo 20 and a row counter that runs modulo 12. Four cursor keys (right, left, down, up) arrive as single-cycle requests. Each one is held in a latch until the next movement phase of the timing sequencer, which moves the matching counter by exactly one step. A Home key captures the page-start (scroll) value into a separate cursor-position register. Apart from the keys, the column counter also advances on display scan characters, during erase and on writes. The row counter advances at the end of each scanned character row. Each of these paths has its own inhibit.

A 3-bit phase input stands in for the timing sequencer and names the current cycle. In the movement phase, pending cursor requests are applied. In the clear phase, pending requests are dropped. At the end of the load phase, both counters take the scroll value, and the cursor register takes it too when Home is pending. All pins are plain control or status levels sampled at the rising clock edge. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `term_cursor_ctrl`

## Requirements
- R1: With `phase` equal to 1 (movement phase), a pending right request increments `col` by one and a pending left request decrements it by one. The new value is visible after that clock edge.
- R2: With `phase` equal to 1, a pending down request increments `row` by one and a pending up request decrements it by one.
- R3: A key pulse in a cycle whose `phase` is not 3 is held until the next movement-phase edge. That edge applies exactly one step and consumes the request, so a second movement phase with no new key leaves the counters unchanged.
- R4: At a clock edge with `phase` equal to 3, all pending movement requests are discarded. A movement phase that follows moves nothing.
- R5: At a clock edge with `phase` equal to 7, `col` and `row` load `scroll_col` and `scroll_row`; a value outside the counter range loads 0. If a Home key arrived in an earlier cycle and is still pending, `cursor_col`/`cursor_row` take the same loaded value at that edge. At every other edge the cursor register holds its value.
- R6: With `scan_active` high, `row_end` increments `row` unless `vblank` or `plot_mode` is high.
- R7: With `scan_active` high, `char_tick` increments `col` unless `vblank` is high.
- R8: With `erase_active` high, `col` increments on every cycle in which `erase_more` is high.
- R9: `write_strobe` increments `col` unless `count_defeat` is high, or unless `end_of_line` is high while `auto_carry` is low.
- R10: `col` wraps from 19 to 0 when counting up and from 0 to 19 when counting down; `row` wraps the same way between 11 and 0.
- R11: When an increment and a decrement source reach the same counter in one cycle, the increment wins. When several increment sources coincide, the counter still moves by a single step.
- R12: Synchronous active-high `rst` clears both counters, the cursor register, the pending Home request and all movement requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 3 | Current timing-sequencer cycle (1 move, 3 clear, 7 load) |
| key_right | input | 1 | Cursor-right key pulse |
| key_left | input | 1 | Cursor-left key pulse |
| key_down | input | 1 | Cursor-down key pulse |
| key_up | input | 1 | Cursor-up key pulse |
| key_home | input | 1 | Home key pulse |
| scan_active | input | 1 | Display scan in progress |
| char_tick | input | 1 | One scanned character done |
| row_end | input | 1 | End of a scanned character row |
| vblank | input | 1 | Vertical blanking active |
| plot_mode | input | 1 | Plot mode (single displayed line) |
| erase_active | input | 1 | Erase cycle in progress |
| erase_more | input | 1 | Erase continues this cycle |
| write_strobe | input | 1 | Character write operation |
| count_defeat | input | 1 | Special-character count defeat |
| end_of_line | input | 1 | Column is at end of line |
| auto_carry | input | 1 | Automatic wrap to next line enabled |
| scroll_col | input | 5 | Page-start column value |
| scroll_row | input | 4 | Page-start row value |
| col | output | 5 | Column address counter |
| row | output | 4 | Row address counter |
| cursor_col | output | 5 | Cursor register, column |
| cursor_row | output | 4 | Cursor register, row |

## Verification
Scan, erase, write and load effects on `col`/`row` appear one edge after the cycle in which their inputs are driven. A cursor key takes two edges: the first latches the request and the movement-phase edge applies it. Home likewise needs the key edge followed by a load-phase edge before the cursor register changes. The bench drives each stimulus at a falling edge and samples the outputs at the next falling edge, after exactly one rising edge. Key-driven cases are split over consecutive table rows, so every row checks the state due after that single edge.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  // index of each cursor direction inside the request vector
  localparam int MV_RIGHT = 0;
  localparam int MV_LEFT  = 1;
  localparam int MV_DOWN  = 2;
  localparam int MV_UP    = 3;
  localparam int MV_N     = 4;

  typedef logic [MV_N-1:0] tcc_moves_t;

  typedef struct packed {
    logic col_up;
    logic col_dn;
    logic row_up;
    logic row_dn;
  } tcc_steps_t;

endpackage

// File: rtl/tcc_move_latch.sv
module tcc_move_latch
  import tcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tcc_moves_t keys,
  input  logic       apply,
  input  logic       clear,
  output tcc_moves_t pend
);

  // one holding latch per direction: new key sets, apply or clear drops
  for (genvar i = 0; i < MV_N; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[i] <= 1'b0;
      end else begin
        pend[i] <= keys[i] | (pend[i] & ~apply & ~clear);
      end
    end
  end

endmodule

// File: rtl/tcc_count_gate.sv
module tcc_count_gate
  import tcc_pkg::*;
(
  input  tcc_moves_t pend,
  input  logic       move_now,
  input  logic       scan_active,
  input  logic       char_tick,
  input  logic       row_end,
  input  logic       vblank,
  input  logic       plot_mode,
  input  logic       erase_active,
  input  logic       erase_more,
  input  logic       write_strobe,
  input  logic       count_defeat,
  input  logic       end_of_line,
  input  logic       auto_carry,
  output tcc_steps_t steps
);

  logic scan_col, scan_row, erase_col, write_col, eol_block;

  always_comb begin
    scan_col  = scan_active & char_tick & ~vblank;
    scan_row  = scan_active & row_end & ~vblank & ~plot_mode;
    erase_col = erase_active & erase_more;
    eol_block = end_of_line & ~auto_carry;
    write_col = write_strobe & ~count_defeat & ~eol_block;

    steps.col_up = (move_now & pend[MV_RIGHT]) | scan_col | erase_col | write_col;
    steps.col_dn = move_now & pend[MV_LEFT];
    steps.row_up = (move_now & pend[MV_DOWN]) | scan_row;
    steps.row_dn = move_now & pend[MV_UP];
  end

endmodule

// File: rtl/tcc_mod_counter.sv
module tcc_mod_counter #(
  parameter int MOD = 20,
  parameter int W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         up,
  input  logic         dn,
  output logic [W-1:0] q,
  output logic [W-1:0] load_eff
);

  localparam logic [W-1:0] LAST = W'(MOD - 1);

  // out-of-range page start values fall back to position 0
  always_comb begin
    load_eff = (int'(load_val) < MOD) ? load_val : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_eff;
    end else if (up) begin
      q <= (q == LAST) ? '0 : q + 1'b1;
    end else if (dn) begin
      q <= (q == '0) ? LAST : q - 1'b1;
    end
  end

endmodule

// File: rtl/term_cursor_ctrl.sv
module term_cursor_ctrl
  import tcc_pkg::*;
#(
  parameter int COLS        = 20,
  parameter int ROWS        = 12,
  parameter int PHASE_W     = 3,
  parameter int MOVE_PHASE  = 1,
  parameter int CLEAR_PHASE = 3,
  parameter int LOAD_PHASE  = 7,
  parameter int COL_W       = $clog2(COLS),
  parameter int ROW_W       = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase,
  input  logic               key_right,
  input  logic               key_left,
  input  logic               key_down,
  input  logic               key_up,
  input  logic               key_home,
  input  logic               scan_active,
  input  logic               char_tick,
  input  logic               row_end,
  input  logic               vblank,
  input  logic               plot_mode,
  input  logic               erase_active,
  input  logic               erase_more,
  input  logic               write_strobe,
  input  logic               count_defeat,
  input  logic               end_of_line,
  input  logic               auto_carry,
  input  logic [COL_W-1:0]   scroll_col,
  input  logic [ROW_W-1:0]   scroll_row,
  output logic [COL_W-1:0]   col,
  output logic [ROW_W-1:0]   row,
  output logic [COL_W-1:0]   cursor_col,
  output logic [ROW_W-1:0]   cursor_row
);

  logic       ph_move, ph_clear, ph_load;
  tcc_moves_t keys, mv_pend;
  tcc_steps_t steps;
  logic       home_pend;
  logic [COL_W-1:0] col_ld;
  logic [ROW_W-1:0] row_ld;

  always_comb begin
    ph_move  = (phase == PHASE_W'(MOVE_PHASE));
    ph_clear = (phase == PHASE_W'(CLEAR_PHASE));
    ph_load  = (phase == PHASE_W'(LOAD_PHASE));
    keys           = '0;
    keys[MV_RIGHT] = key_right;
    keys[MV_LEFT]  = key_left;
    keys[MV_DOWN]  = key_down;
    keys[MV_UP]    = key_up;
  end

  tcc_move_latch u_lat (
    .clk   (clk),
    .rst   (rst),
    .keys  (keys),
    .apply (ph_move),
    .clear (ph_clear),
    .pend  (mv_pend)
  );

  tcc_count_gate u_gate (
    .pend         (mv_pend),
    .move_now     (ph_move),
    .scan_active  (scan_active),
    .char_tick    (char_tick),
    .row_end      (row_end),
    .vblank       (vblank),
    .plot_mode    (plot_mode),
    .erase_active (erase_active),
    .erase_more   (erase_more),
    .write_strobe (write_strobe),
    .count_defeat (count_defeat),
    .end_of_line  (end_of_line),
    .auto_carry   (auto_carry),
    .steps        (steps)
  );

  tcc_mod_counter #(.MOD(COLS), .W(COL_W)) u_col (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (scroll_col),
    .up       (steps.col_up),
    .dn       (steps.col_dn),
    .q        (col),
    .load_eff (col_ld)
  );

  tcc_mod_counter #(.MOD(ROWS), .W(ROW_W)) u_row (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (scroll_row),
    .up       (steps.row_up),
    .dn       (steps.row_dn),
    .q        (row),
    .load_eff (row_ld)
  );

  // Home waits for the end of the load phase, then copies the page start
  always_ff @(posedge clk) begin
    if (rst) begin
      home_pend  <= 1'b0;
      cursor_col <= '0;
      cursor_row <= '0;
    end else begin
      home_pend <= key_home | (home_pend & ~ph_load);
      if (ph_load && home_pend) begin
        cursor_col <= col_ld;
        cursor_row <= row_ld;
      end
    end
  end

endmodule

// File: rtl/term_cursor_ctrl_chk.sv
module term_cursor_ctrl_chk #(
  parameter int COLS        = 20,
  parameter int ROWS        = 12,
  parameter int PHASE_W     = 3,
  parameter int MOVE_PHASE  = 1,
  parameter int CLEAR_PHASE = 3,
  parameter int LOAD_PHASE  = 7,
  parameter int COL_W       = 5,
  parameter int ROW_W       = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] phase,
  input logic [3:0]         keys,
  input logic [3:0]         pend,
  input logic               home_pend,
  input logic               scan_active,
  input logic               vblank,
  input logic               erase_active,
  input logic               write_strobe,
  input logic [COL_W-1:0]   col,
  input logic [ROW_W-1:0]   row,
  input logic [COL_W-1:0]   cursor_col,
  input logic [ROW_W-1:0]   cursor_row
);

  function automatic logic col_near(logic [COL_W-1:0] a, logic [COL_W-1:0] b);
    logic [COL_W-1:0] nx, pv;
    nx = (b == COL_W'(COLS - 1)) ? '0 : b + 1'b1;
    pv = (b == '0) ? COL_W'(COLS - 1) : b - 1'b1;
    return (a == b) || (a == nx) || (a == pv);
  endfunction

  function automatic logic row_near(logic [ROW_W-1:0] a, logic [ROW_W-1:0] b);
    logic [ROW_W-1:0] nx, pv;
    nx = (b == ROW_W'(ROWS - 1)) ? '0 : b + 1'b1;
    pv = (b == '0) ? ROW_W'(ROWS - 1) : b - 1'b1;
    return (a == b) || (a == nx) || (a == pv);
  endfunction

  logic is_load, is_move, is_clear;
  assign is_load  = (phase == PHASE_W'(LOAD_PHASE));
  assign is_move  = (phase == PHASE_W'(MOVE_PHASE));
  assign is_clear = (phase == PHASE_W'(CLEAR_PHASE));

  assert_range_R10: assert property (@(posedge clk) disable iff (rst)
    (int'(col) < COLS) && (int'(row) < ROWS));

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (is_clear && keys == 4'b0) |=> (pend == 4'b0));

  assert_consume_R3: assert property (@(posedge clk) disable iff (rst)
    (is_move && keys == 4'b0) |=> (pend == 4'b0));

  assert_home_R5: assert property (@(posedge clk) disable iff (rst)
    (is_load && home_pend) |=> (cursor_col == col && cursor_row == row));

  assert_cursor_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(is_load && home_pend) |=> ($stable(cursor_col) && $stable(cursor_row)));

  assert_single_step_R11: assert property (@(posedge clk) disable iff (rst)
    !is_load |=> (col_near(col, $past(col)) && row_near(row, $past(row))));

  assert_vblank_R7: assert property (@(posedge clk) disable iff (rst)
    (scan_active && vblank && !is_move && !is_load && !erase_active && !write_strobe)
      |=> ($stable(col) && $stable(row)));

  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (col == '0 && row == '0 && cursor_col == '0 && cursor_row == '0
             && pend == 4'b0 && !home_pend));

endmodule

bind term_cursor_ctrl term_cursor_ctrl_chk #(
  .COLS(COLS), .ROWS(ROWS), .PHASE_W(PHASE_W), .MOVE_PHASE(MOVE_PHASE),
  .CLEAR_PHASE(CLEAR_PHASE), .LOAD_PHASE(LOAD_PHASE), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .phase        (phase),
  .keys         (keys),
  .pend         (mv_pend),
  .home_pend    (home_pend),
  .scan_active  (scan_active),
  .vblank       (vblank),
  .erase_active (erase_active),
  .write_strobe (write_strobe),
  .col          (col),
  .row          (row),
  .cursor_col   (cursor_col),
  .cursor_row   (cursor_row)
);

// File: tb/tb_term_cursor_ctrl.sv
`timescale 1ns/1ps
module tb_term_cursor_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] phase = '0;
  logic       key_right = 0, key_left = 0, key_down = 0, key_up = 0, key_home = 0;
  logic       scan_active = 0, char_tick = 0, row_end = 0, vblank = 0, plot_mode = 0;
  logic       erase_active = 0, erase_more = 0;
  logic       write_strobe = 0, count_defeat = 0, end_of_line = 0, auto_carry = 0;
  logic [4:0] scroll_col = '0;
  logic [3:0] scroll_row = '0;
  logic [4:0] col, cursor_col;
  logic [3:0] row, cursor_row;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  term_cursor_ctrl dut (
    .clk(clk), .rst(rst), .phase(phase),
    .key_right(key_right), .key_left(key_left), .key_down(key_down),
    .key_up(key_up), .key_home(key_home),
    .scan_active(scan_active), .char_tick(char_tick), .row_end(row_end),
    .vblank(vblank), .plot_mode(plot_mode),
    .erase_active(erase_active), .erase_more(erase_more),
    .write_strobe(write_strobe), .count_defeat(count_defeat),
    .end_of_line(end_of_line), .auto_carry(auto_carry),
    .scroll_col(scroll_col), .scroll_row(scroll_row),
    .col(col), .row(row), .cursor_col(cursor_col), .cursor_row(cursor_row)
  );

  // vector: phase[26:24] keys r,l,d,u[23:20] scan,tick,rend,vb,plot[19:15]
  //         erase,more[14:13] wr,def,eol,ac[12:9] exp_col[8:4] exp_row[3:0]
  localparam int NV = 33;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 4'b1000, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd0},  // R3 latch right
    {3'd1, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd1,  4'd0},  // R1 right
    {3'd1, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd1,  4'd0},  // R3 consumed
    {3'd0, 4'b0100, 5'b00000, 2'b00, 4'b0000, 5'd1,  4'd0},
    {3'd1, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd0},  // R1 left
    {3'd0, 4'b0100, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd0},
    {3'd1, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd19, 4'd0},  // R10 0->19
    {3'd0, 4'b1000, 5'b00000, 2'b00, 4'b0000, 5'd19, 4'd0},
    {3'd1, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd0},  // R10 19->0
    {3'd0, 4'b0001, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd0},
    {3'd1, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd11}, // R2 up, wrap
    {3'd0, 4'b0010, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd11},
    {3'd1, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd0},  // R2 down, wrap
    {3'd0, 4'b0010, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd0},
    {3'd1, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd0,  4'd1},  // R2 down
    {3'd0, 4'b0000, 5'b11000, 2'b00, 4'b0000, 5'd1,  4'd1},  // R7 tick
    {3'd0, 4'b0000, 5'b11010, 2'b00, 4'b0000, 5'd1,  4'd1},  // R7 blanked
    {3'd0, 4'b0000, 5'b10100, 2'b00, 4'b0000, 5'd1,  4'd2},  // R6 row end
    {3'd0, 4'b0000, 5'b10110, 2'b00, 4'b0000, 5'd1,  4'd2},  // R6 blanked
    {3'd0, 4'b0000, 5'b10101, 2'b00, 4'b0000, 5'd1,  4'd2},  // R6 plot mode
    {3'd0, 4'b0000, 5'b00000, 2'b11, 4'b0000, 5'd2,  4'd2},  // R8 erase
    {3'd0, 4'b0000, 5'b00000, 2'b11, 4'b0000, 5'd3,  4'd2},  // R8 erase
    {3'd0, 4'b0000, 5'b00000, 2'b10, 4'b0000, 5'd3,  4'd2},  // R8 stopped
    {3'd0, 4'b0000, 5'b00000, 2'b00, 4'b1000, 5'd4,  4'd2},  // R9 write
    {3'd0, 4'b0000, 5'b00000, 2'b00, 4'b1100, 5'd4,  4'd2},  // R9 defeat
    {3'd0, 4'b0000, 5'b00000, 2'b00, 4'b1010, 5'd4,  4'd2},  // R9 eol no carry
    {3'd0, 4'b0000, 5'b00000, 2'b00, 4'b1011, 5'd5,  4'd2},  // R9 eol carry
    {3'd0, 4'b1000, 5'b00000, 2'b00, 4'b0000, 5'd5,  4'd2},
    {3'd3, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd5,  4'd2},  // R4 clear
    {3'd1, 4'b0000, 5'b00000, 2'b00, 4'b0000, 5'd5,  4'd2},  // R4 nothing moves
    {3'd0, 4'b0100, 5'b00000, 2'b00, 4'b0000, 5'd5,  4'd2},
    {3'd1, 4'b0000, 5'b11000, 2'b00, 4'b0000, 5'd6,  4'd2},  // R11 up wins
    {3'd1, 4'b0000, 5'b11000, 2'b00, 4'b1000, 5'd7,  4'd2}   // R11 one step
  };
  localparam string VREQ [NV] = '{
    "R3", "R1", "R3", "R1", "R1", "R10", "R10", "R10", "R10", "R2", "R2",
    "R2", "R2", "R2", "R2", "R7", "R7", "R6", "R6", "R6", "R8", "R8", "R8",
    "R9", "R9", "R9", "R9", "R4", "R4", "R4", "R11", "R11", "R11"
  };

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    phase = 3'd0;
    {key_right, key_left, key_down, key_up, key_home} = '0;
    {scan_active, char_tick, row_end, vblank, plot_mode} = '0;
    {erase_active, erase_more} = '0;
    {write_strobe, count_defeat, end_of_line, auto_carry} = '0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    tick();
    tick();
    // R12 reset state
    check("R12", int'(col), 0, "col after reset");
    check("R12", int'(row), 0, "row after reset");
    check("R12", int'(cursor_col), 0, "cursor_col after reset");
    check("R12", int'(cursor_row), 0, "cursor_row after reset");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      phase = VEC[i][26:24];
      {key_right, key_left, key_down, key_up} = VEC[i][23:20];
      {scan_active, char_tick, row_end, vblank, plot_mode} = VEC[i][19:15];
      {erase_active, erase_more} = VEC[i][14:13];
      {write_strobe, count_defeat, end_of_line, auto_carry} = VEC[i][12:9];
      tick();
      check(VREQ[i], int'(col), int'(VEC[i][8:4]), $sformatf("table[%0d] col", i));
      check(VREQ[i], int'(row), int'(VEC[i][3:0]), $sformatf("table[%0d] row", i));
    end
    idle();
    check("R5", int'(cursor_col), 0, "cursor untouched by moves");

    // R5 Home: key, then load phase copies page start into counters and cursor
    scroll_col = 5'd13; scroll_row = 4'd4;
    key_home = 1'b1;
    tick();
    idle();
    check("R5", int'(cursor_col), 0, "cursor before load phase");
    phase = 3'd7;
    tick();
    idle();
    check("R5", int'(col), 13, "col after load");
    check("R5", int'(cursor_col), 13, "cursor_col after home");
    check("R5", int'(cursor_row), 4, "cursor_row after home");

    // R5 load phase with no Home pending leaves the cursor alone
    scroll_col = 5'd9; scroll_row = 4'd5;
    phase = 3'd7;
    tick();
    idle();
    check("R5", int'(row), 5, "row after plain load");
    check("R5", int'(cursor_col), 13, "cursor_col held");

    // R5 out-of-range page start loads zero
    scroll_col = 5'd25; scroll_row = 4'd14;
    phase = 3'd7;
    tick();
    idle();
    check("R5", int'(col), 0, "col for out-of-range start");
    check("R5", int'(row), 0, "row for out-of-range start");

    // R12 reset drops a pending request and clears the cursor
    key_down = 1'b1;
    tick();
    idle();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R12", int'(cursor_col), 0, "cursor_col after mid reset");
    phase = 3'd1;
    tick();
    idle();
    check("R12", int'(row), 0, "row after reset dropped request");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule